// File: doc/BRIEF.md
# Two-Port Input Change Interrupt

This block raises a single interrupt request for a GPIO expander built from several 8-bit ports. Each port has a snapshot register. The snapshot holds the pin levels that the host last received when it read that port's input register. On every clock, the block compares each pin that is configured as an input with its bit in the snapshot. A difference on any such pin raises that port's request.

The requests of all ports are ORed together and registered. The registered result drives `irq_drive_o`, which is the drive-low enable of an active-low, open-drain interrupt pad. A high value on `irq_drive_o` means the shared line is pulled low.

A request needs no explicit clear. It disappears by itself when the pin goes back to the level held in the snapshot. A read pulse on one port reloads that port's snapshot and clears only that port's request. The first clock after reset loads every snapshot from the pins, so the block leaves reset with nothing pending. Polarity inversion is not an input to this block, so it has no effect on the comparison.

Top module: `gpio_chg_irq`

## Requirements
- R1: While `rst_ni` is low, `irq_drive_o` is 0. On the first clock edge after reset is released, every snapshot is loaded with the current pin levels and no request is raised. `irq_drive_o` stays 0 until a pin changes.
- R2: A pin with `dir_in_i` bit = 1 (input) that differs from its snapshot bit sets `irq_drive_o` to 1 at the next clock edge. Port p uses bits [p*8 +: 8] of `pin_lvl_i` and `dir_in_i`.
- R3: If the differing pin returns to its snapshot level before any read, `irq_drive_o` returns to 0 at the next clock edge.
- R4: `rd_port_i[p]` = 1 for one cycle copies port p's current pin levels into its snapshot. It also masks that port's request in the read cycle. With the pins held, port p raises no request afterwards. A later change relative to the new snapshot raises a request again.
- R5: A read pulse on one port neither clears nor reloads the snapshot of any other port. A pending request on another port keeps `irq_drive_o` at 1.
- R6: A pin with `dir_in_i` bit = 0 (output) never raises a request, whatever its level does.
- R7: Switching a pin from output to input while its level differs from the snapshot raises `irq_drive_o` at the next clock edge. This is the same as a real input change and is not suppressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_lvl_i | input | NPORT*PW (16) | Synchronized pin levels, port p in bits [p*PW +: PW] |
| dir_in_i | input | NPORT*PW (16) | Direction per pin, 1 = input, 0 = output |
| rd_port_i | input | NPORT (2) | One-cycle pulse when the host reads port p's input register |
| irq_drive_o | output | 1 | Drive-low enable of the open-drain interrupt pad |

## Verification
The bench reads port 0 while port 1 has a request pending, and the reverse. A design that cleared every port on any read would drop the line early. The bench also returns a pin to its old level after a read, which must now count as a change. A design that cleared a flag instead of reloading the snapshot would stay quiet. Pins configured as outputs are toggled and then switched back to inputs. This catches a design that watches output pins, and one that masks the spurious interrupt on a direction change. A reset in the middle of a run, with a request pending, shows whether the snapshots are loaded from the pins at reset or are left stale.

// File: rtl/gcirq_pkg.sv
package gcirq_pkg;
  localparam int unsigned DEF_PW    = 8;
  localparam int unsigned DEF_NPORT = 2;
endpackage

// File: rtl/gcirq_prime.sv
// Marks the first clock after reset so snapshots load from the pins.
module gcirq_prime (
  input  logic clk_i,
  input  logic rst_ni,
  output logic primed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_o <= 1'b0;
    else         primed_o <= 1'b1;
  end
endmodule

// File: rtl/gcirq_port_mon.sv
module gcirq_port_mon #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          primed_i,
  input  logic          rd_i,
  input  logic [PW-1:0] pin_i,
  input  logic [PW-1:0] dir_i,
  output logic          req_o
);
  logic [PW-1:0] snap_q;
  logic [PW-1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                snap_q <= '0;
    else if (!primed_i || rd_i) snap_q <= pin_i;
  end

  // output-direction pins are masked out
  assign diff  = (pin_i ^ snap_q) & dir_i;
  assign req_o = primed_i & ~rd_i & (|diff);
endmodule

// File: rtl/gcirq_merge.sv
module gcirq_merge #(
  parameter int unsigned NPORT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPORT-1:0] req_i,
  output logic             drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_o <= 1'b0;
    else         drive_o <= |req_i;
  end
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gcirq_pkg::*;
#(
  parameter int unsigned PW    = DEF_PW,
  parameter int unsigned NPORT = DEF_NPORT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NPORT*PW-1:0] pin_lvl_i,
  input  logic [NPORT*PW-1:0] dir_in_i,
  input  logic [NPORT-1:0]    rd_port_i,
  output logic                irq_drive_o
);
  localparam int unsigned NPIN = NPORT * PW;

  logic             primed_q;
  logic [NPORT-1:0] port_req;
  logic [NPIN-1:0]  pin_w;

  assign pin_w = pin_lvl_i;

  gcirq_prime u_prime (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .primed_o (primed_q)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gcirq_port_mon #(.PW(PW)) u_mon (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .primed_i (primed_q),
      .rd_i     (rd_port_i[p]),
      .pin_i    (pin_w[p*PW +: PW]),
      .dir_i    (dir_in_i[p*PW +: PW]),
      .req_o    (port_req[p])
    );
  end

  gcirq_merge #(.NPORT(NPORT)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (port_req),
    .drive_o (irq_drive_o)
  );
endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk #(
  parameter int unsigned PW    = 8,
  parameter int unsigned NPORT = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NPORT*PW-1:0] pin_lvl_i,
  input logic [NPORT*PW-1:0] dir_in_i,
  input logic [NPORT-1:0]    rd_port_i,
  input logic [NPORT-1:0]    port_req,
  input logic                primed_q,
  input logic                irq_drive_o
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |=> !irq_drive_o);

  p_req_drives_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_req) |=> irq_drive_o);

  p_idle_releases_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|port_req) |=> !irq_drive_o);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    p_read_rearms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_port_i[p] |=> (!$stable(pin_lvl_i[p*PW +: PW]) || !port_req[p]));

    p_outputs_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dir_in_i[p*PW +: PW] == '0) |-> !port_req[p]);
  end
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.PW(PW), .NPORT(NPORT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pin_lvl_i   (pin_lvl_i),
  .dir_in_i    (dir_in_i),
  .rd_port_i   (rd_port_i),
  .port_req    (port_req),
  .primed_q    (primed_q),
  .irq_drive_o (irq_drive_o)
);

// File: tb/tb_gpio_chg_irq.sv
`timescale 1ns/1ps
module tb_gpio_chg_irq;
  localparam int PW = 8;
  localparam int NP = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP*PW-1:0] pins = 16'hA5C3;
  logic [NP*PW-1:0] dir  = 16'hFFFF;
  logic [NP-1:0]  rd = '0;
  logic           irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_chg_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_lvl_i(pins), .dir_in_i(dir),
    .rd_port_i(rd), .irq_drive_o(irq)
  );

  // behavioural reference
  int  m_snap[NP];
  bit  m_primed = 0;
  bit  m_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_primed = 0;
      m_exp = 0;
    end else begin
      bit nxt;
      nxt = 0;
      for (int p = 0; p < NP; p++) begin
        int cur, msk;
        cur = int'(pins[p*PW +: PW]);
        msk = int'(dir[p*PW +: PW]);
        if (m_primed && !rd[p] && (((cur ^ m_snap[p]) & msk) != 0)) nxt = 1;
      end
      for (int p = 0; p < NP; p++)
        if (!m_primed || rd[p]) m_snap[p] = int'(pins[p*PW +: PW]);
      m_primed = 1;
      m_exp = nxt;
    end
  end

  always @(posedge clk) begin
    #1;
    n_chk++;
    if (irq !== m_exp) begin
      n_fail++;
      $display("FAIL R2 per-cycle model: actual %0b expected %0b at %0t", irq, m_exp, $time);
    end
  end

  task automatic chk(input bit exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, irq, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic rd_pulse(input int p);
    rd[p] = 1'b1; step(); rd[p] = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    chk(0, "R1 during reset");
    rst_n = 1'b1;
    step(); step();
    chk(0, "R1 after reset");

    pins[3] = ~pins[3]; step();
    chk(1, "R2 input change port0");
    pins[3] = ~pins[3]; step();
    chk(0, "R3 return to old level");

    pins[3] = ~pins[3]; step();
    chk(1, "R2 change again");
    rd_pulse(0);
    chk(0, "R4 read clears");
    step();
    chk(0, "R4 stays clear");
    pins[3] = ~pins[3]; step();
    chk(1, "R4 snapshot reloaded");
    rd_pulse(0);
    chk(0, "R4 second read");

    pins[10] = ~pins[10]; pins[1] = ~pins[1]; step();
    chk(1, "R5 both ports pending");
    rd_pulse(0);
    chk(1, "R5 port1 survives port0 read");
    rd_pulse(1);
    chk(0, "R5 port1 read clears");

    pins[2] = ~pins[2]; step();
    rd_pulse(1);
    chk(1, "R5 port0 survives port1 read");
    rd_pulse(0);
    chk(0, "R5 port0 read clears");

    dir = 16'hFF00; step();
    pins[7:0] = ~pins[7:0]; step();
    chk(0, "R6 output pins ignored");
    pins[7:0] = pins[7:0] ^ 8'h5A; step(); step();
    chk(0, "R6 output pins toggled");

    dir = 16'hFFFF; step();
    chk(1, "R7 output to input mismatch");
    rd_pulse(0);
    chk(0, "R7 cleared by read");

    pins[12] = ~pins[12]; step();
    chk(1, "R2 port1 change");
    rst_n = 1'b0; #0.5;
    chk(0, "R1 async reset");
    step(); rst_n = 1'b1; step(); step();
    chk(0, "R1 snapshot loaded at reset");

    repeat (4) step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule